// File: doc/BRIEF.md
# Multicast Receive Address Filter

This block decides, packet by packet, whether a receiver keeps an incoming frame. It looks only at the frame's 8-bit destination host byte, which arrives with a one-cycle valid strobe at the start of the packet. One cycle later it returns a keep/drop verdict. A host register selects the filtering mode. Any value other than all ones names a single station, and frames for that station or for the broadcast address 0 are kept. The all-ones value switches to multicast mode. In that mode a 256-entry acceptance vector, indexed by the destination byte, decides alone. Clearing entry 0 of the vector therefore refuses broadcast frames.

Software loads the vector as sixteen 16-bit words, and should do so before it writes all ones to the host register. The block also counts frames that were kept but found no receive buffer free. This count saturates and is cleared by a software strobe. At end of packet the block also builds the receive status byte from error strobes gathered over the packet.

Top module: `rx_dest_filter`

## Requirements
- R1: While the host register is not all ones, a packet is kept exactly when its destination equals the low 8 bits of the host register or equals 0.
- R2: While the host register is all ones, a packet is kept exactly when vector entry [destination] is 1.
- R3: Writing word k (vec_sel = k) of the vector sets entry 16*k + j to bit j of vec_wdata. Other words are unchanged.
- R4: In multicast mode, broadcast (destination 0) follows vector entry 0 only, so clearing that entry rejects broadcast frames.
- R5: keep_valid is high for exactly the one cycle after each dst_valid cycle. keep is low whenever keep_valid is low.
- R6: A host or vector write in the same cycle as dst_valid does not affect that packet's verdict. It applies to the next packet.
- R7: One cycle after rx_eop, eop_valid pulses and eop_status holds the error strobes seen since the previous end of packet, including the rx_eop cycle itself: collision at bit 7, data late at bit 5, CRC bad at bit 3, bad termination at bit 0, other bits 0. The gathered errors then restart from zero.
- R8: miss_count goes up by one, in the same cycle as keep_valid, when a kept packet had buf_ready low at its dst_valid cycle. Dropped packets and packets with a buffer leave it unchanged.
- R9: miss_count saturates at its all-ones value.
- R10: miss_clr sets miss_count to 0 on the next cycle. It wins over a coincident increment.
- R11: After reset the host register is 0, the vector is all zeros, miss_count is 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host register write strobe |
| host_wdata | input | HOST_W | Host register write value (all ones = multicast) |
| vec_we | input | 1 | Vector word write strobe |
| vec_sel | input | SEL_W | Vector word index |
| vec_wdata | input | WORD_W | Vector word value |
| miss_clr | input | 1 | Clear missed-packet counter |
| dst_valid | input | 1 | Destination byte valid (packet start) |
| dst_addr | input | ADDR_W | Destination host byte |
| buf_ready | input | 1 | A receive buffer is available |
| rx_coll | input | 1 | Collision strobe |
| rx_late | input | 1 | Input data late strobe |
| rx_crc_bad | input | 1 | CRC bad strobe |
| rx_badend | input | 1 | Bad packet termination strobe |
| rx_eop | input | 1 | End of packet |
| keep_valid | output | 1 | Verdict valid |
| keep | output | 1 | Keep the packet |
| miss_count | output | MISS_W | Missed-packet counter |
| eop_valid | output | 1 | Status byte valid |
| eop_status | output | 8 | End-of-packet status byte |

## Verification
Two pairs of events can land in the same cycle. A configuration write can coincide with a packet's destination strobe, and a counter clear can coincide with a missed packet. The bench drives a host write and a vector write on the very cycle of dst_valid, then checks that the verdict follows the old setting and that the next packet follows the new one. It also raises miss_clr on the cycle of a packet that would count as missed, and expects zero afterwards.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int ADDR_W = 8,
  parameter int HOST_W = 16,
  parameter int WORD_W = 16,
  parameter int MISS_W = 16,
  localparam int ENTRIES = 1 << ADDR_W,
  localparam int NWORDS = ENTRIES / WORD_W,
  localparam int SEL_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              vec_we,
  input  logic [SEL_W-1:0]  vec_sel,
  input  logic [WORD_W-1:0] vec_wdata,
  input  logic              miss_clr,
  input  logic              dst_valid,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              buf_ready,
  input  logic              rx_coll,
  input  logic              rx_late,
  input  logic              rx_crc_bad,
  input  logic              rx_badend,
  input  logic              rx_eop,
  output logic              keep_valid,
  output logic              keep,
  output logic [MISS_W-1:0] miss_count,
  output logic              eop_valid,
  output logic [7:0]        eop_status
);
  localparam int COLL_B = 7;
  localparam int LATE_B = 5;
  localparam int CRC_B  = 3;
  localparam int TERM_B = 0;

  logic [HOST_W-1:0]  host_q;
  logic [ENTRIES-1:0] vec_q;
  logic [7:0]         err_acc;
  logic [7:0]         err_now;

  wire multi   = &host_q;
  wire hit     = multi ? vec_q[dst_addr]
                       : (dst_addr == host_q[ADDR_W-1:0]) || (dst_addr == '0);
  wire miss_ev = dst_valid & hit & ~buf_ready;
  wire sat     = &miss_count;

  always_comb begin
    err_now = '0;
    err_now[COLL_B] = rx_coll;
    err_now[LATE_B] = rx_late;
    err_now[CRC_B]  = rx_crc_bad;
    err_now[TERM_B] = rx_badend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q <= '0;
      vec_q  <= '0;
    end else begin
      if (host_we) host_q <= host_wdata;
      if (vec_we)  vec_q[vec_sel*WORD_W +: WORD_W] <= vec_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_valid <= 1'b0;
      keep       <= 1'b0;
    end else begin
      keep_valid <= dst_valid;
      keep       <= dst_valid & hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                miss_count <= '0;
    else if (miss_clr)         miss_count <= '0;
    else if (miss_ev && !sat)  miss_count <= miss_count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_acc    <= '0;
      eop_valid  <= 1'b0;
      eop_status <= '0;
    end else begin
      eop_valid <= rx_eop;
      if (rx_eop) begin
        eop_status <= err_acc | err_now;
        err_acc    <= '0;
      end else begin
        err_acc <= err_acc | err_now;
      end
    end
  end
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dst_valid,
  input logic              miss_clr,
  input logic              rx_eop,
  input logic              keep_valid,
  input logic              keep,
  input logic [MISS_W-1:0] miss_count,
  input logic              eop_valid
);
  localparam logic [MISS_W-1:0] MAXV = '1;

  assert_verdict_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> keep_valid);
  assert_no_spurious_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !keep_valid);
  assert_keep_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !keep_valid |-> !keep);
  assert_eop_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |=> eop_valid);
  assert_no_spurious_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_eop |=> !eop_valid);
  assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dst_valid && !miss_clr) |=> $stable(miss_count));
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_clr |=> (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + 1'b1));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == MAXV && !miss_clr) |=> miss_count == MAXV);
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_clr |=> miss_count == '0);
endmodule

bind rx_dest_filter rx_dest_filter_chk #(.MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .miss_clr(miss_clr),
  .rx_eop(rx_eop), .keep_valid(keep_valid), .keep(keep),
  .miss_count(miss_count), .eop_valid(eop_valid)
);

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;
  localparam int MW = 4;

  logic clk = 0, rst_n = 0;
  logic host_we = 0, vec_we = 0, miss_clr = 0, dst_valid = 0, buf_ready = 1;
  logic rx_coll = 0, rx_late = 0, rx_crc_bad = 0, rx_badend = 0, rx_eop = 0;
  logic [15:0] host_wdata = 0, vec_wdata = 0;
  logic [3:0] vec_sel = 0;
  logic [7:0] dst_addr = 0;
  logic keep_valid, keep, eop_valid;
  logic [MW-1:0] miss_count;
  logic [7:0] eop_status;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_dest_filter #(.MISS_W(MW)) i_rx_dest_filter (.*);

  // {host, dst, expected keep}
  localparam int NT = 18;
  localparam logic [24:0] TBL [0:NT-1] = '{
    {16'h0042, 8'h42, 1'b1}, {16'h0042, 8'h00, 1'b1}, {16'h0042, 8'h43, 1'b0},
    {16'h0042, 8'hFF, 1'b0}, {16'h00FF, 8'hFF, 1'b1}, {16'h7FFF, 8'hFF, 1'b1},
    {16'h7FFF, 8'h03, 1'b0}, {16'hFFFF, 8'h03, 1'b1}, {16'hFFFF, 8'h04, 1'b0},
    {16'hFFFF, 8'hFF, 1'b1}, {16'hFFFF, 8'hFE, 1'b0}, {16'hFFFF, 8'h00, 1'b1},
    {16'hFFFF, 8'h11, 1'b0}, {16'hFFFF, 8'h12, 1'b1}, {16'hFFFF, 8'hF0, 1'b1},
    {16'hFFFF, 8'hF1, 1'b0}, {16'hFFFF, 8'h42, 1'b1}, {16'hFFFF, 8'h43, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_host(input logic [15:0] v);
    @(negedge clk); host_we = 1; host_wdata = v;
    @(negedge clk); host_we = 0;
  endtask

  task automatic wr_vec(input logic [3:0] k, input logic [15:0] v);
    @(negedge clk); vec_we = 1; vec_sel = k; vec_wdata = v;
    @(negedge clk); vec_we = 0;
  endtask

  task automatic pkt(input logic [7:0] d, input logic br, output logic kv, output logic kp);
    @(negedge clk); dst_valid = 1; dst_addr = d; buf_ready = br;
    @(negedge clk); dst_valid = 0; buf_ready = 1; host_we = 0; vec_we = 0; miss_clr = 0;
    kv = keep_valid; kp = keep;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic kv, kp;
    logic [15:0] cur_host;
    repeat (3) @(negedge clk);
    chk("R11 keep_valid", keep_valid, 0);
    chk("R11 keep", keep, 0);
    chk("R11 miss_count", miss_count, 0);
    chk("R11 eop_valid", eop_valid, 0);
    rst_n = 1;
    pkt(8'h05, 1, kv, kp); chk("R11 host 0 rejects 5", kp, 0);
    pkt(8'h00, 1, kv, kp); chk("R11 host 0 keeps broadcast", kp, 1);
    pkt(8'h00, 1, kv, kp);
    wr_host(16'hFFFF);
    pkt(8'h00, 1, kv, kp); chk("R11 empty vector", kp, 0);
    wr_host(16'h0000);

    // R3: entry i set iff i%3==0
    for (int k = 0; k < 16; k++) begin
      logic [15:0] w;
      for (int j = 0; j < 16; j++) w[j] = ((16*k + j) % 3 == 0);
      wr_vec(k[3:0], w);
    end

    cur_host = 16'h0000;
    for (int i = 0; i < NT; i++) begin
      if (TBL[i][24:9] != cur_host) begin
        cur_host = TBL[i][24:9];
        wr_host(cur_host);
      end
      pkt(TBL[i][8:1], 1, kv, kp);
      chk(cur_host == 16'hFFFF ? "R2/R3 multicast" : "R1 single host", kp, TBL[i][0]);
      chk("R5 verdict valid", kv, 1);
    end
    @(negedge clk); chk("R5 single pulse", keep_valid, 0);

    // R4: clear entry 0 keeps others of word 0
    wr_vec(4'd0, 16'h9248);
    pkt(8'h00, 1, kv, kp); chk("R4 broadcast refused", kp, 0);
    pkt(8'h03, 1, kv, kp); chk("R4 entry 3 still kept", kp, 1);
    pkt(8'h0F, 1, kv, kp); chk("R3 entry 15", kp, 1);

    // R6: vector write same cycle as packet
    @(negedge clk); vec_we = 1; vec_sel = 0; vec_wdata = 16'h0010;
    dst_valid = 1; dst_addr = 8'h04;
    @(negedge clk); vec_we = 0; dst_valid = 0;
    chk("R6 vector write same cycle", keep, 0);
    pkt(8'h04, 1, kv, kp); chk("R6 vector write later", kp, 1);
    // R6: host write same cycle as packet
    @(negedge clk); host_we = 1; host_wdata = 16'h0050; dst_valid = 1; dst_addr = 8'h04;
    @(negedge clk); host_we = 0; dst_valid = 0;
    chk("R6 host write same cycle", keep, 1);
    pkt(8'h04, 1, kv, kp); chk("R6 single mode after", kp, 0);
    pkt(8'h50, 1, kv, kp); chk("R6 new host", kp, 1);

    // R8 missed counting
    pkt(8'h50, 0, kv, kp); chk("R8 kept without buffer", miss_count, 1);
    pkt(8'h51, 0, kv, kp); chk("R8 dropped without buffer", miss_count, 1);
    pkt(8'h00, 1, kv, kp); chk("R8 kept with buffer", miss_count, 1);
    // R9 saturation
    for (int n = 0; n < 20; n++) pkt(8'h00, 0, kv, kp);
    chk("R9 saturate", miss_count, 15);
    // R10 clear
    @(negedge clk); miss_clr = 1;
    @(negedge clk); miss_clr = 0;
    chk("R10 clear", miss_count, 0);
    pkt(8'h00, 0, kv, kp); chk("R10 count again", miss_count, 1);
    @(negedge clk); miss_clr = 1; dst_valid = 1; dst_addr = 8'h00; buf_ready = 0;
    @(negedge clk); miss_clr = 0; dst_valid = 0; buf_ready = 1;
    chk("R10 clear wins", miss_count, 0);

    // R7 status byte
    @(negedge clk); rx_coll = 1;
    @(negedge clk); rx_coll = 0; rx_crc_bad = 1;
    @(negedge clk); rx_crc_bad = 0;
    @(negedge clk); chk("R7 no early status", eop_valid, 0);
    rx_late = 1; rx_eop = 1;
    @(negedge clk); rx_late = 0; rx_eop = 0;
    chk("R7 eop_valid", eop_valid, 1);
    chk("R7 status bits", eop_status, 8'hA8);
    @(negedge clk); chk("R7 eop pulse ends", eop_valid, 0);
    rx_badend = 1; rx_eop = 1;
    @(negedge clk); rx_badend = 0; rx_eop = 0;
    chk("R7 restart after eop", eop_status, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule